// File: doc/BRIEF.md
# Speaker Driver Short-Circuit Guard

This block decides when each of two speaker output drivers may run. Every channel has an over-current flag and an over-temperature flag from the analog sensing, and either flag counts as a fault. The block turns the driver enable off when a fault appears and restores it under one of two policies, chosen by a mode input.

In auto-retry mode a faulted driver is switched off for a fixed number of time-base ticks. It is then switched back on and the fault is sampled again. If the fault is still there the off period starts over, and this repeats until the fault goes away. Each such trip sets a sticky per-channel status bit. In latched mode the driver keeps running while the fault is debounced over a much longer tick count. If the fault lasts the whole window, the driver is shut down and held off, and an emergency status bit is set. The hold is released only by a clear pulse given while the fault is absent.

An interrupt line combines the status bits. The emergency bit's share of the interrupt can be masked, and the bit stays readable at its port while masked. All times are counted in ticks of an external time base, so the default parameters give millisecond-scale and second-scale windows while tests can use small counts.

Top module: `spk_short_guard`

## Requirements
- R1: After reset both driver enables are 1, and every status bit and the interrupt are 0.
- R2: In auto-retry mode (latch_mode_i=0), a running channel that samples a fault at a clock edge has its enable at 0 and its trip status bit at 1 from that edge on. A fault is over-current OR over-temperature.
- R3: An auto-retry off period lasts exactly OFF_TICKS tick pulses. The enable returns to 1 at the edge that takes the OFF_TICKS-th tick, so a channel is low for between (OFF_TICKS-1)*P+1 and OFF_TICKS*P cycles when ticks come every P cycles.
- R4: If the fault persists, each re-enable lasts exactly one cycle before the channel turns off again, and the cycle repeats. Once the fault is gone, the channel stays enabled.
- R5: In latched mode (latch_mode_i=1) the enable stays 1 during debounce. A fault that disappears before DEB_TICKS ticks causes no shutdown and sets no status.
- R6: In latched mode, a fault present through DEB_TICKS ticks drives the enable to 0 and sets emerg_stat_o. The enable then stays 0 for as long as the fault is present.
- R7: clr_i has no effect on a latched channel while its fault is present. With the fault absent, one clr_i cycle re-enables the channel and clears emerg_stat_o at the next edge.
- R8: trip_stat_o bit 0 belongs to the left channel (index 0) and bit 1 to the right channel (index 1). Each bit stays set until a clr_i cycle clears it.
- R9: irq_o = (OR of trip_stat_o) OR (emerg_stat_o AND NOT emerg_mask_i). A mask of 1 leaves emerg_stat_o unchanged.
- R10: The channels are independent: a fault on one channel never changes the enable of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| ocur_i | input | NCH | Over-current flag per channel |
| otemp_i | input | NCH | Over-temperature flag per channel |
| latch_mode_i | input | 1 | 0: auto-retry, 1: debounced latched shutdown |
| emerg_mask_i | input | 1 | Masks the emergency bit out of irq_o |
| clr_i | input | 1 | Clears status and releases latched channels |
| drv_en_o | output | NCH | Driver enable per channel |
| trip_stat_o | output | NCH | Sticky auto-retry trip flag per channel |
| emerg_stat_o | output | 1 | Latched emergency shutdown flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong channel state shows directly at drv_en_o, because the enable is decoded straight from the channel state. A missed trip is visible one edge after the fault is sampled. A wrong tick counter shows up as an off period or a debounce window outside its bounds, measured in whole tick periods. A latch that releases too early, or a status bit that drops on its own, shows at drv_en_o, emerg_stat_o or irq_o on the cycle after the clear pulse, or while the fault is held.

// File: rtl/scp_pkg.sv
// Package: shared channel state encoding for the speaker short-circuit guard.
// Assumes: a single channel is in exactly one of the four states.
package scp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,  // driver enabled, fault watched
        ST_OFF   = 2'd1,  // retry back-off, driver disabled
        ST_DEB   = 2'd2,  // latched-mode debounce, driver still enabled
        ST_LATCH = 2'd3   // emergency shutdown held
    } scp_state_e;
endpackage

// File: rtl/scp_tick_timer.sv
// Module: scp_tick_timer
// Counts tick pulses while run is high and flags the pulse that reaches
// last+1 ticks. Returns to zero whenever run is low.
// Assumes: last is held stable while run stays high.
module scp_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] last,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Completion flag: the tick that closes the window.
    assign done = run && tick && (cnt == last);

    // Tick counter, cleared outside a window and at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= done ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/scp_chan_fsm.sv
// Module: scp_chan_fsm
// One channel's protection sequencer: auto-retry back-off or debounced
// latched shutdown, chosen by latch_mode when a fault first appears.
// Assumes: fault is already synchronous to clk.
module scp_chan_fsm
    import scp_pkg::*;
#(
    parameter int CW        = 8,
    parameter int OFF_TICKS = 47,
    parameter int DEB_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault,
    input  logic latch_mode,
    input  logic clr,
    output logic drv_en,
    output logic retry_trip,
    output logic latch_trip,
    output logic in_deb,
    output logic in_latch,
    output logic hold
);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
    localparam logic [CW-1:0] DEB_LAST = CW'(DEB_TICKS - 1);

    scp_state_e    state, state_nx;
    logic          t_run, t_done;
    logic [CW-1:0] t_last;

    // Timer runs during back-off and debounce, with the matching length.
    assign t_run  = (state == ST_OFF) || (state == ST_DEB);
    assign t_last = (state == ST_DEB) ? DEB_LAST : OFF_LAST;

    scp_tick_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (t_run),
        .tick (tick),
        .last (t_last),
        .done (t_done)
    );

    // Next-state decision for the channel.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (fault) state_nx = latch_mode ? ST_DEB : ST_OFF;
            ST_OFF:   if (t_done) state_nx = ST_RUN;
            ST_DEB:   if (!fault) state_nx = ST_RUN;
                      else if (t_done) state_nx = ST_LATCH;
            ST_LATCH: if (clr && !fault) state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Decoded outputs and single-cycle trip events.
    assign drv_en     = (state == ST_RUN) || (state == ST_DEB);
    assign retry_trip = (state == ST_RUN) && fault && !latch_mode;
    assign latch_trip = (state == ST_DEB) && fault && t_done;
    assign in_deb     = (state == ST_DEB);
    assign in_latch   = (state == ST_LATCH);
    assign hold       = in_latch && fault;
endmodule

// File: rtl/scp_irq_collect.sv
// Module: scp_irq_collect
// Keeps the sticky trip and emergency flags and forms the interrupt.
// Assumes: trip inputs are single-cycle events; set wins over clear.
module scp_irq_collect #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           mask,
    input  logic [NCH-1:0] retry_trip,
    input  logic [NCH-1:0] latch_trip,
    input  logic [NCH-1:0] hold,
    output logic [NCH-1:0] stat,
    output logic           emerg,
    output logic           irq
);
    // Per-channel sticky trip flags.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= retry_trip | (stat & {NCH{!clr}});
    end

    // Emergency flag, kept while any channel is still held by its fault.
    always_ff @(posedge clk) begin
        if (!rst_n)          emerg <= 1'b0;
        else if (|latch_trip) emerg <= 1'b1;
        else if (clr && !(|hold)) emerg <= 1'b0;
    end

    // Interrupt request with a maskable emergency contribution.
    assign irq = (|stat) || (emerg && !mask);
endmodule

// File: rtl/spk_short_guard.sv
// Module: spk_short_guard (top)
// Short-circuit and over-temperature guard for NCH speaker drivers. Times
// are counted in tick_i pulses.
// Assumes: fault flags are synchronous to clk; tick_i is one cycle wide.
module spk_short_guard #(
    parameter int NCH       = 2,
    parameter int OFF_TICKS = 47,
    parameter int DEB_TICKS = 16300
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [NCH-1:0] ocur_i,
    input  logic [NCH-1:0] otemp_i,
    input  logic           latch_mode_i,
    input  logic           emerg_mask_i,
    input  logic           clr_i,
    output logic [NCH-1:0] drv_en_o,
    output logic [NCH-1:0] trip_stat_o,
    output logic           emerg_stat_o,
    output logic           irq_o
);
    localparam int MAXT = (OFF_TICKS > DEB_TICKS) ? OFF_TICKS : DEB_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [NCH-1:0] fault, retry_trip, latch_trip, ch_deb, ch_latch, ch_hold;

    // Either sensed condition counts as a fault.
    assign fault = ocur_i | otemp_i;

    // One sequencer per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        scp_chan_fsm #(
            .CW       (CW),
            .OFF_TICKS(OFF_TICKS),
            .DEB_TICKS(DEB_TICKS)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_i),
            .fault     (fault[c]),
            .latch_mode(latch_mode_i),
            .clr       (clr_i),
            .drv_en    (drv_en_o[c]),
            .retry_trip(retry_trip[c]),
            .latch_trip(latch_trip[c]),
            .in_deb    (ch_deb[c]),
            .in_latch  (ch_latch[c]),
            .hold      (ch_hold[c])
        );
    end

    scp_irq_collect #(.NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_i),
        .mask      (emerg_mask_i),
        .retry_trip(retry_trip),
        .latch_trip(latch_trip),
        .hold      (ch_hold),
        .stat      (trip_stat_o),
        .emerg     (emerg_stat_o),
        .irq       (irq_o)
    );
endmodule

// File: rtl/scp_guard_chk.sv
// Module: scp_guard_chk
// Temporal checks on the guard, attached to the top by bind.
// Assumes: bound to spk_short_guard with matching NCH.
module scp_guard_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic [NCH-1:0] fault,
    input logic           latch_mode_i,
    input logic           emerg_mask_i,
    input logic           clr_i,
    input logic [NCH-1:0] drv_en_o,
    input logic [NCH-1:0] trip_stat_o,
    input logic [NCH-1:0] ch_deb,
    input logic [NCH-1:0] ch_latch,
    input logic           irq_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R2: a running channel in retry mode turns off on a fault
        a_r2_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_en_o[c] && !ch_deb[c] && fault[c] && !latch_mode_i) |=> !drv_en_o[c]);
        // R3: back-off cannot end without a tick
        a_r3_no_tick_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!drv_en_o[c] && !ch_latch[c] && !tick_i) |=> !drv_en_o[c]);
        // R5: debounce keeps the driver running
        a_r5_deb_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            ch_deb[c] |-> drv_en_o[c]);
        // R6: latched channel with fault present stays off
        a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_latch[c] && fault[c]) |=> !drv_en_o[c]);
        // R8: trip flag is sticky without clear
        a_r8_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_stat_o[c] && !clr_i) |=> trip_stat_o[c]);
    end
    // R9: masked emergency alone raises no interrupt
    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (emerg_mask_i && (trip_stat_o == '0)) |-> !irq_o);
endmodule

bind spk_short_guard scp_guard_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .fault       (fault),
    .latch_mode_i(latch_mode_i),
    .emerg_mask_i(emerg_mask_i),
    .clr_i       (clr_i),
    .drv_en_o    (drv_en_o),
    .trip_stat_o (trip_stat_o),
    .ch_deb      (ch_deb),
    .ch_latch    (ch_latch),
    .irq_o       (irq_o)
);

// File: tb/spk_short_guard_bench.sv
// Directed bench for spk_short_guard with scaled-down tick counts.
module spk_short_guard_bench;
    localparam int NCH = 2;
    localparam int OFFT = 5;
    localparam int DEBT = 6;
    localparam int P = 4;  // cycles per tick

    logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
    logic [NCH-1:0] ocur_i = '0, otemp_i = '0;
    logic latch_mode_i = 1'b0, emerg_mask_i = 1'b0, clr_i = 1'b0;
    logic [NCH-1:0] drv_en_o, trip_stat_o;
    logic emerg_stat_o, irq_o;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    spk_short_guard #(.NCH(NCH), .OFF_TICKS(OFFT), .DEB_TICKS(DEBT)) u_spk_short_guard (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ocur_i(ocur_i), .otemp_i(otemp_i),
        .latch_mode_i(latch_mode_i), .emerg_mask_i(emerg_mask_i), .clr_i(clr_i),
        .drv_en_o(drv_en_o), .trip_stat_o(trip_stat_o),
        .emerg_stat_o(emerg_stat_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // Time base: one tick every P cycles, driven away from the active edge.
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tick_i = (tc == P - 1);
            tc = (tc == P - 1) ? 0 : tc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; cyc(1); clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(drv_en_o == 2'b11, "R1 enables", drv_en_o, 3);
        chk(trip_stat_o == 0, "R1 trip status", trip_stat_o, 0);
        chk(emerg_stat_o == 0 && irq_o == 0, "R1 emerg/irq", {emerg_stat_o, irq_o}, 0);
    endtask

    // Retry-mode fault that clears during back-off.
    task automatic t_retry_clear();
        int low = 0;
        latch_mode_i = 1'b0;
        ocur_i[0] = 1'b1; cyc(1);
        chk(drv_en_o[0] == 0, "R2 trip off", drv_en_o[0], 0);
        chk(trip_stat_o == 2'b01, "R8 left bit", trip_stat_o, 1);
        chk(irq_o == 1, "R9 irq from trip", irq_o, 1);
        chk(drv_en_o[1] == 1, "R10 other channel", drv_en_o[1], 1);
        ocur_i[0] = 1'b0;
        while (!drv_en_o[0] && low < 100) begin low++; cyc(1); end
        chk(low >= (OFFT-1)*P+1 && low <= OFFT*P, "R3 off length", low, OFFT*P);
        cyc(40);
        chk(drv_en_o[0] == 1, "R4 stays on after clear", drv_en_o[0], 1);
        chk(trip_stat_o[0] == 1, "R8 sticky", trip_stat_o[0], 1);
        pulse_clr();
        chk(trip_stat_o == 0 && irq_o == 0, "R8 cleared", {trip_stat_o, irq_o}, 0);
    endtask

    // Retry-mode fault that persists on the right channel.
    task automatic t_retry_persist();
        int highs = 0, rises = 0, other_low = 0;
        bit prev = 1'b0;
        otemp_i[1] = 1'b1; cyc(1);
        chk(trip_stat_o == 2'b10, "R8 right bit", trip_stat_o, 2);
        for (int k = 0; k < 90; k++) begin
            if (drv_en_o[1]) highs++;
            if (drv_en_o[1] && !prev) rises++;
            if (!drv_en_o[0]) other_low++;
            prev = drv_en_o[1];
            cyc(1);
        end
        chk(rises >= 3, "R4 repeated retries", rises, 3);
        chk(highs == rises, "R4 one-cycle re-enable", highs, rises);
        chk(other_low == 0, "R10 left untouched", other_low, 0);
        otemp_i[1] = 1'b0; cyc(OFFT*P + 5);
        chk(drv_en_o[1] == 1, "R4 recovers", drv_en_o[1], 1);
        pulse_clr();
    endtask

    // Latched mode, fault shorter than the debounce.
    task automatic t_latch_short();
        int low = 0;
        latch_mode_i = 1'b1;
        ocur_i[0] = 1'b1;
        for (int k = 0; k < 10; k++) begin cyc(1); if (!drv_en_o[0]) low++; end
        ocur_i[0] = 1'b0; cyc(30);
        chk(low == 0, "R5 enabled in debounce", low, 0);
        chk(emerg_stat_o == 0 && trip_stat_o == 0, "R5 no status",
            {emerg_stat_o, trip_stat_o}, 0);
    endtask

    // Latched mode, fault through the debounce, clear and mask.
    task automatic t_latch_long();
        int high = 0;
        emerg_mask_i = 1'b0;
        otemp_i[0] = 1'b1; cyc(1);
        while (drv_en_o[0] && high < 100) begin high++; cyc(1); end
        chk(high >= (DEBT-1)*P+1 && high <= DEBT*P, "R6 debounce length", high, DEBT*P);
        chk(emerg_stat_o == 1 && irq_o == 1, "R6 emergency raised",
            {emerg_stat_o, irq_o}, 3);
        chk(trip_stat_o == 0, "R6 no trip bit", trip_stat_o, 0);
        cyc(50);
        chk(drv_en_o[0] == 0, "R6 held off", drv_en_o[0], 0);
        pulse_clr();
        chk(drv_en_o[0] == 0 && emerg_stat_o == 1, "R7 clear ignored with fault",
            {drv_en_o[0], emerg_stat_o}, 1);
        emerg_mask_i = 1'b1; cyc(1);
        chk(irq_o == 0, "R9 masked irq", irq_o, 0);
        chk(emerg_stat_o == 1, "R9 status readable", emerg_stat_o, 1);
        otemp_i[0] = 1'b0; cyc(5);
        chk(drv_en_o[0] == 0, "R7 no release without clear", drv_en_o[0], 0);
        pulse_clr();
        chk(drv_en_o[0] == 1 && emerg_stat_o == 0, "R7 release",
            {drv_en_o[0], emerg_stat_o}, 2);
        emerg_mask_i = 1'b0; latch_mode_i = 1'b0;
    endtask

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset();
        t_retry_clear();
        t_retry_persist();
        t_latch_short();
        t_latch_long();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule